// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

A 2048-byte memory shared by two processors, one on a left port and one on a right port. Each port is synchronous to the common clock and has its own chip enable, write enable, 11-bit address, write data and registered read data. Either side can read any byte at any time. The two processors exchange messages through the array and signal each other through two mailbox bytes at the top of the address space.

A write by the right side to address 0x7FE raises the left interrupt. Any access by the left side to that address lowers it. A write by the left side to 0x7FF raises the right interrupt, and any right access to 0x7FF lowers it. Both bytes still store data like any other location.

When both ports hit the same address in one cycle, an internal collision detector blocks the write of the side whose enable became active more recently. If both enables became active in the same cycle, the right side is blocked. No port sees the collision, so software must keep the two sides off the same byte at the same time.

Top module: `mbox_dpram`

## Requirements
- R1: A byte written through either port is returned on either port's read data one clock after a later enabled access to the same address presents that address.
- R2: Read data of a port changes only on a cycle in which that port's chip enable is high. Otherwise it holds its last value.
- R3: When one port reads an address in the same cycle as the other port's write to it takes effect, the read returns the byte stored before that write.
- R4: On a same-address collision where both enables became active in the same cycle, the left write is stored and the right write is blocked.
- R5: On a same-address collision where one enable became active in a later cycle than the other, the later side's write is blocked and the earlier side's write is stored.
- R6: While both enables stay high without a new activation, the order of their last activations keeps deciding which write is blocked.
- R7: Writes from both ports to different addresses in the same cycle are both stored.
- R8: A write by the right port to 0x7FE that is not blocked sets the left interrupt output high from the next cycle.
- R9: Any enabled left access to 0x7FE clears the left interrupt from the next cycle, unless a set hits it in the same cycle.
- R10: A write by the left port to 0x7FF that is not blocked sets the right interrupt output. Any enabled right access to 0x7FF clears it, unless a set hits it in the same cycle.
- R11: When a set and a clear hit the same interrupt flag in the same cycle, the flag ends up set.
- R12: Addresses 0x7FE and 0x7FF store and return data like any other address.
- R13: Reset (rstN low) drives both interrupt outputs and both read data outputs to zero.
- R14: A blocked write neither changes the stored byte nor sets an interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| lCe | input | 1 | Left chip enable |
| lWe | input | 1 | Left write enable (qualified by lCe) |
| lAddr | input | 11 | Left byte address |
| lWdata | input | 8 | Left write data |
| lRdata | output | 8 | Left registered read data |
| lIrq | output | 1 | Interrupt to the left processor, active high |
| rCe | input | 1 | Right chip enable |
| rWe | input | 1 | Right write enable (qualified by rCe) |
| rAddr | input | 11 | Right byte address |
| rWdata | input | 8 | Right write data |
| rRdata | output | 8 | Right registered read data |
| rIrq | output | 1 | Interrupt to the right processor, active high |

## Verification
The only hidden state is the per-port enable history and the interrupt flags. If the activation order is tracked wrongly, the wrong byte survives a collision. That shows up only when the address is read back, at least two cycles after the collision. A flag that is set or cleared wrongly appears on the interrupt output on the very next clock. A wrong read-port register shows as changed or stale read data one cycle after the access. The bench therefore reads each collided address back and samples the interrupt outputs every cycle around mailbox accesses.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Write strobes issued by the control to the storage array after collision gating.
  typedef struct packed {
    logic lWr;
    logic rWr;
  } wrStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCe,
  input  logic              lWe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              rCe,
  input  logic              rWe,
  input  logic [ADDR_W-1:0] rAddr,
  output wrStrobe_t         strb,
  output logic              lIrq,
  output logic              rIrq
);
  localparam logic [ADDR_W-1:0] MBOX_L = ADDR_W'((1 << ADDR_W) - 2);
  localparam logic [ADDR_W-1:0] MBOX_R = ADDR_W'((1 << ADDR_W) - 1);

  logic lCeQ, rCeQ, leftNewerQ;
  logic lRise, rRise, sameAddr, leftLater;
  logic lSet, lClr, rSet, rClr;

  assign lRise    = lCe & ~lCeQ;
  assign rRise    = rCe & ~rCeQ;
  assign sameAddr = lCe & rCe & (lAddr == rAddr);

  // A new right activation always counts as latest (right also loses ties).
  always_comb begin
    if (rRise)      leftLater = 1'b0;
    else if (lRise) leftLater = 1'b1;
    else            leftLater = leftNewerQ;
  end

  assign strb.lWr = lCe & lWe & ~(sameAddr & leftLater);
  assign strb.rWr = rCe & rWe & ~(sameAddr & ~leftLater);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lCeQ       <= 1'b0;
      rCeQ       <= 1'b0;
      leftNewerQ <= 1'b0;
    end else begin
      lCeQ <= lCe;
      rCeQ <= rCe;
      if (rRise)      leftNewerQ <= 1'b0;
      else if (lRise) leftNewerQ <= 1'b1;
    end
  end

  assign lSet = strb.rWr & (rAddr == MBOX_L);
  assign lClr = lCe & (lAddr == MBOX_L);
  assign rSet = strb.lWr & (lAddr == MBOX_R);
  assign rClr = rCe & (rAddr == MBOX_R);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lIrq <= 1'b0;
      rIrq <= 1'b0;
    end else begin
      lIrq <= lSet | (lIrq & ~lClr);
      rIrq <= rSet | (rIrq & ~rClr);
    end
  end

  // R4
  tie_left_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lRise && rRise && sameAddr && lWe) |-> (strb.lWr && !strb.rWr));
  // R5
  one_writer_chk: assert property (@(posedge clk) disable iff (!rstN)
    sameAddr |-> !(strb.lWr && strb.rWr));
  // R8
  l_irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rWr && rAddr == MBOX_L) |=> lIrq);
  // R9
  l_irq_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lCe && lAddr == MBOX_L && !(strb.rWr && rAddr == MBOX_L)) |=> !lIrq);
  // R10
  r_irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lWr && lAddr == MBOX_R) |=> rIrq);
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strb,
  input  logic              lCe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  output logic [DATA_W-1:0] lRdata,
  input  logic              rCe,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] rRdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Collision gating in the control guarantees the two strobes never hit one address.
  always_ff @(posedge clk) begin
    if (strb.lWr) mem[lAddr] <= lWdata;
    if (strb.rWr) mem[rAddr] <= rWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lRdata <= '0;
      rRdata <= '0;
    end else begin
      if (lCe) lRdata <= mem[lAddr];
      if (rCe) rRdata <= mem[rAddr];
    end
  end

  // R2
  l_rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lCe |=> $stable(lRdata));
  // R2
  r_rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rCe |=> $stable(rRdata));
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCe,
  input  logic              lWe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  output logic [DATA_W-1:0] lRdata,
  output logic              lIrq,
  input  logic              rCe,
  input  logic              rWe,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] rRdata,
  output logic              rIrq
);
  wrStrobe_t strb;

  mbox_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lCe(lCe), .lWe(lWe), .lAddr(lAddr),
    .rCe(rCe), .rWe(rWe), .rAddr(rAddr),
    .strb(strb), .lIrq(lIrq), .rIrq(rIrq)
  );

  mbox_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lCe(lCe), .lAddr(lAddr), .lWdata(lWdata), .lRdata(lRdata),
    .rCe(rCe), .rAddr(rAddr), .rWdata(rWdata), .rRdata(rRdata)
  );
endmodule

// File: tb/mbox_dpram_test.sv
`timescale 1ns/1ps
module mbox_dpram_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lCe = 0, lWe = 0, rCe = 0, rWe = 0;
  logic [10:0] lAddr = '0, rAddr = '0;
  logic [7:0] lWdata = '0, rWdata = '0;
  logic [7:0] lRdata, rRdata;
  logic lIrq, rIrq;
  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mbox_dpram uut (
    .clk(clk), .rstN(rstN),
    .lCe(lCe), .lWe(lWe), .lAddr(lAddr), .lWdata(lWdata), .lRdata(lRdata), .lIrq(lIrq),
    .rCe(rCe), .rWe(rWe), .rAddr(rAddr), .rWdata(rWdata), .rRdata(rRdata), .rIrq(rIrq)
  );

  typedef struct packed {
    logic lc; logic lw; logic [10:0] la; logic [7:0] ld;
    logic rc; logic rw; logic [10:0] ra; logic [7:0] rd;
    logic cl; logic [7:0] el; logic cr; logic [7:0] er;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,11'h010,8'hA5, 1'b0,1'b0,11'h000,8'h00, 1'b0,8'h00, 1'b0,8'h00},
    '{1'b0,1'b0,11'h000,8'h00, 1'b1,1'b1,11'h020,8'h3C, 1'b0,8'h00, 1'b0,8'h00},
    '{1'b1,1'b0,11'h020,8'h00, 1'b1,1'b0,11'h010,8'h00, 1'b1,8'h3C, 1'b1,8'hA5},
    '{1'b1,1'b1,11'h011,8'h5A, 1'b1,1'b1,11'h021,8'hC3, 1'b0,8'h00, 1'b0,8'h00},
    '{1'b1,1'b0,11'h021,8'h00, 1'b1,1'b0,11'h011,8'h00, 1'b1,8'hC3, 1'b1,8'h5A},
    '{1'b0,1'b0,11'h000,8'h00, 1'b0,1'b0,11'h000,8'h00, 1'b1,8'hC3, 1'b1,8'h5A},
    '{1'b1,1'b1,11'h012,8'h99, 1'b0,1'b0,11'h000,8'h00, 1'b0,8'h00, 1'b1,8'h5A},
    '{1'b0,1'b0,11'h000,8'h00, 1'b0,1'b0,11'h000,8'h00, 1'b0,8'h00, 1'b1,8'h5A},
    '{1'b0,1'b0,11'h000,8'h00, 1'b1,1'b1,11'h012,8'hEE, 1'b0,8'h00, 1'b0,8'h00},
    '{1'b1,1'b0,11'h012,8'h00, 1'b1,1'b1,11'h012,8'h44, 1'b1,8'hEE, 1'b0,8'h00},
    '{1'b1,1'b0,11'h012,8'h00, 1'b0,1'b0,11'h000,8'h00, 1'b1,8'h44, 1'b0,8'h00},
    '{1'b0,1'b0,11'h000,8'h00, 1'b1,1'b0,11'h012,8'h00, 1'b1,8'h44, 1'b1,8'h44}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge; outputs are valid at the next falling edge.
  task automatic step(input logic lc, input logic lw, input logic [10:0] la, input logic [7:0] ld,
                      input logic rc, input logic rw, input logic [10:0] ra, input logic [7:0] rd);
    lCe = lc; lWe = lw; lAddr = la; lWdata = ld;
    rCe = rc; rWe = rw; rAddr = ra; rWdata = rd;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 11'h0, 8'h0, 0, 0, 11'h0, 8'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 lIrq", {7'b0, lIrq}, 8'h00);
    chk("R13 rIrq", {7'b0, rIrq}, 8'h00);
    chk("R13 lRdata", lRdata, 8'h00);
    chk("R13 rRdata", rRdata, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R7 table walk
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].lc, VECS[i].lw, VECS[i].la, VECS[i].ld,
           VECS[i].rc, VECS[i].rw, VECS[i].ra, VECS[i].rd);
      if (VECS[i].cl) chk($sformatf("R1/R2/R3/R7 vec%0d left", i), lRdata, VECS[i].el);
      if (VECS[i].cr) chk($sformatf("R1/R2/R7 vec%0d right", i), rRdata, VECS[i].er);
    end

    // R4: both enables rise together, left wins
    idle();
    step(1, 1, 11'h100, 8'h11, 1, 1, 11'h100, 8'h22);
    idle();
    step(1, 0, 11'h100, 8'h00, 0, 0, 11'h0, 8'h00);
    chk("R4 tie keeps left byte", lRdata, 8'h11);

    // R5: right enabled first, left rises later and is blocked
    idle();
    step(0, 0, 11'h0, 8'h00, 1, 0, 11'h101, 8'h00);
    step(1, 1, 11'h101, 8'h44, 1, 1, 11'h101, 8'h33);
    step(1, 0, 11'h101, 8'h00, 1, 0, 11'h101, 8'h00);
    chk("R5 later left blocked (left read)", lRdata, 8'h33);
    chk("R5 later left blocked (right read)", rRdata, 8'h33);
    // R6: both held, left still the later one
    step(1, 1, 11'h101, 8'h55, 1, 1, 11'h101, 8'h66);
    idle();
    step(1, 0, 11'h101, 8'h00, 0, 0, 11'h0, 8'h00);
    chk("R6 remembered order", lRdata, 8'h66);

    // R8 R9 R12 left mailbox at 0x7FE
    idle();
    step(0, 0, 11'h0, 8'h00, 1, 1, 11'h7FE, 8'hAB);
    chk("R8 lIrq set", {7'b0, lIrq}, 8'h01);
    chk("R8 rIrq untouched", {7'b0, rIrq}, 8'h00);
    step(0, 0, 11'h0, 8'h00, 1, 0, 11'h7FE, 8'h00);
    chk("R12 right reads 0x7FE", rRdata, 8'hAB);
    chk("R9 right access keeps lIrq", {7'b0, lIrq}, 8'h01);
    step(1, 0, 11'h7FE, 8'h00, 0, 0, 11'h0, 8'h00);
    chk("R12 left reads 0x7FE", lRdata, 8'hAB);
    chk("R9 lIrq cleared", {7'b0, lIrq}, 8'h00);

    // R10 right mailbox at 0x7FF
    idle();
    step(1, 1, 11'h7FF, 8'hCD, 0, 0, 11'h0, 8'h00);
    chk("R10 rIrq set", {7'b0, rIrq}, 8'h01);
    step(0, 0, 11'h0, 8'h00, 1, 0, 11'h7FF, 8'h00);
    chk("R12 right reads 0x7FF", rRdata, 8'hCD);
    chk("R10 rIrq cleared", {7'b0, rIrq}, 8'h00);

    // R11 set beats clear
    idle();
    step(1, 1, 11'h7FF, 8'h12, 0, 0, 11'h0, 8'h00);
    step(1, 1, 11'h7FF, 8'hEF, 1, 0, 11'h7FF, 8'h00);
    chk("R11 rIrq stays set", {7'b0, rIrq}, 8'h01);
    chk("R3 right sees old mailbox byte", rRdata, 8'h12);
    idle();
    chk("R11 rIrq still set", {7'b0, rIrq}, 8'h01);
    step(0, 0, 11'h0, 8'h00, 1, 0, 11'h7FF, 8'h00);
    chk("R10 right reads new byte", rRdata, 8'hEF);
    chk("R10 rIrq cleared after", {7'b0, rIrq}, 8'h00);

    // R14 blocked write neither stores nor sets
    idle();
    step(0, 0, 11'h0, 8'h00, 1, 1, 11'h7FE, 8'h77);
    chk("R8 lIrq set again", {7'b0, lIrq}, 8'h01);
    idle();
    step(1, 0, 11'h7FE, 8'h00, 1, 1, 11'h7FE, 8'h99);
    chk("R14 blocked write sets nothing", {7'b0, lIrq}, 8'h00);
    chk("R14 left read old byte", lRdata, 8'h77);
    idle();
    step(1, 0, 11'h7FE, 8'h00, 0, 0, 11'h0, 8'h00);
    chk("R14 byte unchanged", lRdata, 8'h77);

    // R13 reset in mid-run
    step(0, 0, 11'h0, 8'h00, 1, 1, 11'h7FE, 8'h01);
    chk("R8 lIrq before reset", {7'b0, lIrq}, 8'h01);
    idle();
    rstN = 1'b0;
    #1;
    chk("R13 lIrq after reset", {7'b0, lIrq}, 8'h00);
    chk("R13 lRdata after reset", lRdata, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule